// File: doc/BRIEF.md
# Port Change Interrupt and Core Control Register

This block monitors a six-bit general-purpose port and raises an interrupt request when a qualified pin changes level. Each pin level passes through a two-stage synchronizer. A third stage keeps the previous sampled value, and comparing the two gives a per-pin change vector. The lower three pins always qualify. Each of the upper three qualifies only while its function-select input marks it as a general-purpose input or I/O pin. The data direction plays no part in qualification. Firmware can therefore toggle a pin it drives as an output and get an interrupt back, which gives a software-triggered interrupt path.

The block also holds an 8-bit core control register that sits on a simple single-cycle register bus. That register holds:
- a port-wide pull-up disable bit,
- a sleep enable bit,
- a sleep-mode select bit (idle or power-down),
- two sense-control bits that go unchanged to a separate external-interrupt unit.

A second register address holds the interrupt enable and the sticky change flag. A sleep request from the core takes effect only while sleep enable is set. Any interrupt request that is raised wakes the block from sleep.

Top module: `pcint_ctrl`

## Requirements
- R1: A level change on pin 0, 1 or 2 sets the change flag whatever the value of `pin_gp_i`.
- R2: A level change on pin 3, 4 or 5 sets the change flag only when the matching `pin_gp_i` bit is 1. When that bit is 0 the change is ignored.
- R3: Detection depends only on the pin level and not on who drives the pin. Toggling a pin that the chip drives as an output sets the flag and, when enabled, raises `irq_o`.
- R4: A pin held at a new level for at least one full clock period is detected. The flag is visible set after the third rising clock edge that follows the change.
- R5: The flag (address 1, bit 1) stays set until `ack_i` is high for one cycle or a write to address 1 has bit 1 = 1. If a qualified change arrives in the same cycle as a clear, the flag stays set.
- R6: `irq_o` is high exactly while the flag is set and the enable bit (address 1, bit 0, read/write) is 1.
- R7: The control register is at address 0. Bits 7, 3 and 2 always read 0 and ignore writes. All bits reset to 0. Address 1 bits 7:2 read 0.
- R8: When control bit 6 is 1, all `pu_en_o` bits are 0. When it is 0, `pu_en_o` equals `pu_req_i`.
- R9: Control bit 5 is sleep enable and bit 4 is sleep mode (0 = idle, 1 = power-down). A `sleep_req_i` pulse sets `sleep_o` on the next edge only if bit 5 is 1. `sleep_pd_o` is `sleep_o` AND bit 4.
- R10: While `irq_o` is high, `sleep_o` is cleared on the next clock edge, and this takes priority over a sleep request.
- R11: Control bits 1:0 are read/write and appear unchanged on `isc_o`. They have no effect on pin-change flagging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 6 | Port pin levels (asynchronous) |
| pin_gp_i | input | 6 | 1 = pin used as general-purpose input or I/O (only bits 5:3 matter) |
| pu_req_i | input | 6 | Per-pin pull-up requests from the port logic |
| reg_addr_i | input | 1 | Register select: 0 = control, 1 = interrupt enable/flag |
| reg_wr_i | input | 1 | Write strobe, one cycle |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register (combinational) |
| ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| sleep_req_i | input | 1 | Sleep request pulse from the core |
| irq_o | output | 1 | Pin-change interrupt request |
| sleep_o | output | 1 | Sleep state |
| sleep_pd_o | output | 1 | Sleep state is power-down |
| pu_en_o | output | 6 | Effective pull-up enables |
| isc_o | output | 2 | External-interrupt sense control |

## Verification
The assertions assume that `pin_gp_i`, `reg_*`, `ack_i` and `sleep_req_i` are synchronous to `clk` and change only away from the rising edge. Only `pin_i` may be asynchronous. The bench drives every input, including the pin levels, on the falling edge, so no setup race can arise. It changes `pin_gp_i` in the same cycle as the pins. It holds each configuration for several cycles before it reads back the flag.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
    localparam int CR_W      = 8;
    localparam int PUD_BIT   = 6;
    localparam int SE_BIT    = 5;
    localparam int SM_BIT    = 4;
    localparam int ISC_LSB   = 0;
    localparam int ISC_W     = 2;
    localparam int EN_BIT    = 0;
    localparam int FLAG_BIT  = 1;

    typedef struct packed {
        logic             pud;
        logic             se;
        logic             sm;
        logic [ISC_W-1:0] isc;
    } ctrl_t;
endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
    parameter int NPINS   = 6,
    parameter int NALWAYS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] gp_i,
    output logic [NPINS-1:0] chg_o
);
    typedef struct packed {
        logic [NPINS-1:0] s1;
        logic [NPINS-1:0] s2;
        logic [NPINS-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;
    logic [NPINS-1:0] qual;

    for (genvar i = 0; i < NPINS; i++) begin : g_qual
        if (i < NALWAYS) begin : g_fixed
            assign qual[i] = 1'b1;
        end else begin : g_gated
            assign qual[i] = gp_i[i];
        end
    end

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        chg_o   = (st_q.s2 ^ st_q.s3) & qual;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        if (i < NALWAYS) begin : g_a
            // R1
            always_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.s2[i] != st_q.s3[i]) |-> chg_o[i]);
        end else begin : g_b
            // R2
            gated_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !gp_i[i] |-> !chg_o[i]);
        end
    end
endmodule

// File: rtl/pcint_creg.sv
module pcint_creg
    import pcint_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [CR_W-1:0] wdata_i,
    output ctrl_t           ctrl_o,
    output logic [CR_W-1:0] rdata_o
);
    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.pud = wdata_i[PUD_BIT];
            st_d.se  = wdata_i[SE_BIT];
            st_d.sm  = wdata_i[SM_BIT];
            st_d.isc = wdata_i[ISC_LSB +: ISC_W];
        end
        rdata_o                  = '0;
        rdata_o[PUD_BIT]         = st_q.pud;
        rdata_o[SE_BIT]          = st_q.se;
        rdata_o[SM_BIT]          = st_q.sm;
        rdata_o[ISC_LSB +: ISC_W] = st_q.isc;
        ctrl_o                   = st_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    se_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ctrl_o.se == $past(wdata_i[SE_BIT]));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(rdata_o));
endmodule

// File: rtl/pcint_irq.sv
module pcint_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_any_i,
    input  logic en_wr_i,
    input  logic en_wdata_i,
    input  logic clr_i,
    input  logic sleep_req_i,
    input  logic se_i,
    input  logic sm_i,
    output logic en_o,
    output logic flag_o,
    output logic irq_o,
    output logic sleep_o,
    output logic sleep_pd_o
);
    typedef struct packed {
        logic en;
        logic flag;
        logic sleep;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        irq_o = st_q.flag & st_q.en;
        if (en_wr_i)   st_d.en   = en_wdata_i;
        if (clr_i)     st_d.flag = 1'b0;
        if (chg_any_i) st_d.flag = 1'b1;
        if (sleep_req_i && se_i) st_d.sleep = 1'b1;
        if (irq_o)     st_d.sleep = 1'b0;
        en_o       = st_q.en;
        flag_o     = st_q.flag;
        sleep_o    = st_q.sleep;
        sleep_pd_o = st_q.sleep & sm_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_any_i |=> flag_o);
    // R5
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !chg_any_i) |=> !flag_o);
    // R10
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !sleep_o);
    // R9
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> $past(sleep_req_i && se_i));
endmodule

// File: rtl/pcint_ctrl.sv
module pcint_ctrl
    import pcint_pkg::*;
#(
    parameter int NPINS   = 6,
    parameter int NALWAYS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] pin_gp_i,
    input  logic [NPINS-1:0] pu_req_i,
    input  logic             reg_addr_i,
    input  logic             reg_wr_i,
    input  logic [CR_W-1:0]  reg_wdata_i,
    output logic [CR_W-1:0]  reg_rdata_o,
    input  logic             ack_i,
    input  logic             sleep_req_i,
    output logic             irq_o,
    output logic             sleep_o,
    output logic             sleep_pd_o,
    output logic [NPINS-1:0] pu_en_o,
    output logic [ISC_W-1:0] isc_o
);
    logic [NPINS-1:0] chg;
    logic [CR_W-1:0]  cr_rdata;
    ctrl_t            ctrl;
    logic             en, flag;
    logic             wr_cr, wr_ie, clr;

    assign wr_cr = reg_wr_i && !reg_addr_i;
    assign wr_ie = reg_wr_i &&  reg_addr_i;
    assign clr   = ack_i || (wr_ie && reg_wdata_i[FLAG_BIT]);

    pcint_sync #(.NPINS(NPINS), .NALWAYS(NALWAYS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .gp_i(pin_gp_i), .chg_o(chg)
    );

    pcint_creg u_creg (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_cr), .wdata_i(reg_wdata_i),
        .ctrl_o(ctrl), .rdata_o(cr_rdata)
    );

    pcint_irq u_irq (
        .clk(clk), .rst_n(rst_n), .chg_any_i(|chg),
        .en_wr_i(wr_ie), .en_wdata_i(reg_wdata_i[EN_BIT]), .clr_i(clr),
        .sleep_req_i(sleep_req_i), .se_i(ctrl.se), .sm_i(ctrl.sm),
        .en_o(en), .flag_o(flag), .irq_o(irq_o),
        .sleep_o(sleep_o), .sleep_pd_o(sleep_pd_o)
    );

    always_comb begin
        pu_en_o = ctrl.pud ? '0 : pu_req_i;
        isc_o   = ctrl.isc;
        if (reg_addr_i) begin
            reg_rdata_o           = '0;
            reg_rdata_o[EN_BIT]   = en;
            reg_rdata_o[FLAG_BIT] = flag;
        end else begin
            reg_rdata_o = cr_rdata;
        end
    end

    // R8
    pud_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pud |-> pu_en_o == '0));
    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (flag && en));
endmodule

// File: tb/pcint_ctrl_test.sv
module pcint_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pin_i = '0, pin_gp_i = '0, pu_req_i = 6'h2A;
    logic       reg_addr_i = 1'b0, reg_wr_i = 1'b0, ack_i = 1'b0, sleep_req_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       irq_o, sleep_o, sleep_pd_o;
    logic [5:0] pu_en_o;
    logic [1:0] isc_o;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pcint_ctrl uut (.*);

    // {new pin levels, function select, expected flag}
    localparam logic [12:0] VEC [8] = '{
        {6'b000001, 6'b000000, 1'b1},   // pin0, always
        {6'b001001, 6'b000000, 1'b0},   // pin3 gated off
        {6'b001001, 6'b111000, 1'b0},   // select change only
        {6'b011001, 6'b010000, 1'b1},   // pin4 enabled
        {6'b111001, 6'b011000, 1'b0},   // pin5 gated off
        {6'b111101, 6'b000000, 1'b1},   // pin2, always
        {6'b011101, 6'b100000, 1'b1},   // pin5 enabled
        {6'b011111, 6'b000000, 1'b1}    // pin1, always
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        step(1);
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr_i = a;
        #1 d = reg_rdata_o;
    endtask

    initial begin
        logic [7:0] r;
        step(2);
        rst_n = 1'b1;
        step(1);
        // reset state
        rd(0, r); chk("R7 ctrl reset", r, 8'h00);
        rd(1, r); chk("R7 ie reset", r, 8'h00);
        chk("R6 irq reset", irq_o, 0);
        chk("R8 pullup pass", pu_en_o, 6'h2A);

        for (int k = 0; k < 8; k++) begin
            pin_i = VEC[k][12:7]; pin_gp_i = VEC[k][6:1];
            step(4);
            rd(1, r); chk($sformatf("R1/R2 vector %0d", k), r[1], VEC[k][0]);
            if (k % 2 == 0) wr(1, 8'h02);
            else begin ack_i = 1'b1; step(1); ack_i = 1'b0; end
            rd(1, r); chk($sformatf("R5 clear vector %0d", k), r[1], 0);
        end
        pin_gp_i = '0;

        // register layout
        wr(0, 8'hFF);
        rd(0, r); chk("R7 reserved read zero", r, 8'h73);
        chk("R11 isc out", isc_o, 2'b11);
        chk("R8 pullups forced off", pu_en_o, 6'h00);
        wr(1, 8'hFF);
        rd(1, r); chk("R7 ie reserved zero", r, 8'h01);
        wr(0, 8'h02);
        chk("R11 isc 10", isc_o, 2'b10);
        chk("R8 pullups pass again", pu_en_o, 6'h2A);

        // latency, flag independent of isc, irq
        pin_i[0] = ~pin_i[0];
        step(2);
        rd(1, r); chk("R4 not before third edge", r[1], 0);
        step(1);
        rd(1, r); chk("R4 R11 flag at third edge", r[1], 1);
        chk("R6 irq with enable", irq_o, 1);
        wr(1, 8'h00);
        chk("R6 irq off when disabled", irq_o, 0);
        rd(1, r); chk("R6 flag kept", r[1], 1);

        // change in same cycle as acknowledge
        pin_i[1] = ~pin_i[1];
        step(2);
        ack_i = 1'b1; step(1); ack_i = 1'b0;
        rd(1, r); chk("R5 change beats clear", r[1], 1);
        ack_i = 1'b1; step(1); ack_i = 1'b0;
        rd(1, r); chk("R5 ack clears", r[1], 0);

        // one-cycle pulse
        pin_i[2] = ~pin_i[2]; step(1); pin_i[2] = ~pin_i[2];
        step(3);
        rd(1, r); chk("R4 one-cycle pulse", r[1], 1);
        wr(1, 8'h02);

        // sleep
        sleep_req_i = 1'b1; step(1); sleep_req_i = 1'b0;
        chk("R9 no sleep without enable", sleep_o, 0);
        wr(0, 8'h30);
        sleep_req_i = 1'b1; step(1); sleep_req_i = 1'b0;
        chk("R9 sleep entered", sleep_o, 1);
        chk("R9 power-down", sleep_pd_o, 1);
        wr(0, 8'h20);
        chk("R9 idle mode", sleep_pd_o, 0);

        // software interrupt via output-driven pin, wakes sleep
        wr(1, 8'h01);
        pin_gp_i[5] = 1'b1;
        pin_i[5] = ~pin_i[5];
        step(3);
        chk("R3 toggled output raises irq", irq_o, 1);
        step(1);
        chk("R10 irq wakes", sleep_o, 0);
        sleep_req_i = 1'b1; step(1); sleep_req_i = 1'b0;
        chk("R10 irq beats sleep request", sleep_o, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule